// File: doc/BRIEF.md
# EDO DRAM Page-Mode Controller

A synchronous controller placed between a simple host request port and a 16-bit-wide extended-data-out DRAM with a multiplexed 10-bit address bus. The host presents word or byte requests: a 20-bit word address, a write flag, a two-bit byte-lane enable and write data. Requests are accepted through a valid/ready handshake. The upper half of the address selects the row and the lower half selects the column. Read data comes back as a one-cycle valid pulse with 16 bits of data.

The controller leaves a row open after an access. A later request to the same row reuses the open page with only a column strobe. A request to another row first closes the page, waits out the precharge time and then opens the new row. The page is also closed on its own before the row-active time limit is reached.

A free-running interval timer schedules CAS-before-RAS refresh cycles. A pending refresh blocks new host requests. It waits for the access in flight to finish and for the open page to close before it starts. If a refresh is still waiting when the next one falls due, a sticky overdue flag is set. Every timing value is a parameter counted in controller clock cycles.

Top module: `edo_page_ctrl`

## Requirements
- R1: Out of reset, dramRasN, dramCasLN, dramCasHN, dramWeN and dramOeN are all high, rdValid and refreshOverdue are low, and reqReady is high.
- R2: When RAS falls for an access, dramAddr carries reqAddr[19:10]. When CAS falls, dramAddr carries reqAddr[9:0]. RAS is low for at least T_RCD cycles before the first CAS fall of that row.
- R3: Lane control follows reqBe. reqBe[0] drives dramCasLN, which selects DQ[7:0]. reqBe[1] drives dramCasHN, which selects DQ[15:8]. A lane that is not enabled keeps its CAS high. A write holds dramWeN low and dramDqOe high, with reqWdata on dramDqOut, while CAS is low.
- R4: A read holds dramOeN low while CAS is low. It samples dramDqIn on the last CAS cycle and returns that word on rdData with a single-cycle rdValid pulse.
- R5: A request to the row already open is served with no new RAS fall. CAS stays high for at least T_CP cycles between page accesses.
- R6: A request to a different row raises RAS. RAS then stays high for at least T_RP cycles before the new row is opened.
- R7: A refresh falls due every T_REFI cycles. In a refresh, both CAS lines go low at least T_CSR cycles before RAS falls, with dramWeN high, and stay low for T_CHR cycles after RAS falls.
- R8: A pending refresh stops new requests from being accepted. The refresh starts only after the open page has closed and RAS has been high for at least T_RP cycles.
- R9: RAS never stays low for more than T_RASMAX cycles. An idle open page is closed when its row-active time nears that limit.
- R10: refreshOverdue is set when a refresh falls due while the previous one has not started. Once set, it stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Controller accepts the request on this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 20 | Word address, row in [19:10], column in [9:0] |
| reqBe | input | 2 | Byte-lane enables, bit 0 low byte, bit 1 high byte |
| reqWdata | input | 16 | Write data |
| rdValid | output | 1 | One-cycle read-data valid pulse |
| rdData | output | 16 | Returned read data |
| refreshOverdue | output | 1 | Sticky flag: a refresh was delayed past its interval |
| dramRasN | output | 1 | Row strobe, active low |
| dramCasLN | output | 1 | Low-byte column strobe, active low |
| dramCasHN | output | 1 | High-byte column strobe, active low |
| dramWeN | output | 1 | Write enable, active low |
| dramOeN | output | 1 | Output enable, active low |
| dramAddr | output | 10 | Multiplexed row/column address |
| dramDqOut | output | 16 | Write data toward the DRAM |
| dramDqOe | output | 1 | Drive enable for dramDqOut |
| dramDqIn | input | 16 | Read data from the DRAM |

## Verification
The bench targets byte-lane steering. If the lane mapping were swapped or a disabled lane strobed, the byte-write and byte-read readbacks would come back with the wrong or corrupted half-word.

It checks that back-to-back same-row requests reuse the page and that a row change reopens it. A controller that ignored the open-row compare would either reopen every time or return data from the wrong row.

It also counts refreshes over an idle window and measures the CAS-before-RAS setup, the precharge gap and the longest RAS-low run. This exposes a scheduler that misses refreshes, starts one with the page open, or leaves a page open past the row-active limit. A second instance with an interval shorter than one refresh cycle must raise the overdue flag and keep it set.

// File: rtl/edo_pkg.sv
`timescale 1ns/1ps
package edo_pkg;
  localparam int DATA_W = 16;
  localparam int LANES  = DATA_W / 8;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RCD, ST_OPEN, ST_CAS, ST_CP, ST_PRE, ST_RCSR, ST_RCHR, ST_RHOLD
  } edoState_e;

  typedef struct packed {
    logic latchReq;  // capture the host request
    logic casOn;     // data-access column strobe phase
    logic refCas;    // refresh: all lanes low
    logic capture;   // last column cycle, sample read data
  } edoStrobe_t;
endpackage

// File: rtl/edo_ctrl.sv
`timescale 1ns/1ps
module edo_ctrl
  import edo_pkg::*;
#(
  parameter int T_RCD    = 6,
  parameter int T_CAS    = 3,
  parameter int T_CP     = 2,
  parameter int T_RP     = 9,
  parameter int T_RASMIN = 12,
  parameter int T_RASMAX = 20000,
  parameter int T_REFI   = 3120,
  parameter int T_CSR    = 2,
  parameter int T_CHR    = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       rowHit,
  output logic       reqReady,
  output logic       rasN,
  output edoStrobe_t strobe,
  output logic       refreshOverdue
);
  localparam int CW       = $clog2(T_RCD + T_CAS + T_CP + T_RP + T_CSR + T_RASMIN + 1);
  localparam int AW       = $clog2(T_RASMAX + 1);
  localparam int RW       = $clog2(T_REFI + 1);
  localparam int CLOSE_AT = T_RASMAX - (T_CAS + T_CP + 2);

  edoState_e     state, stateNext;
  logic [CW-1:0] cnt, cntNext;
  logic [AW-1:0] rasLowCnt;
  logic [RW-1:0] refTimer;
  logic refPending, refFire, rasLowNow, minMet, nearMax, accept, takeRef;

  always_comb begin
    rasLowNow = state inside {ST_RCD, ST_OPEN, ST_CAS, ST_CP, ST_RCHR, ST_RHOLD};
    minMet    = rasLowCnt >= AW'(T_RASMIN);
    nearMax   = rasLowCnt >= AW'(CLOSE_AT);
    reqReady  = !refPending && ((state == ST_IDLE) || (state == ST_OPEN && rowHit && !nearMax));
    accept    = reqValid && reqReady;
    takeRef   = (state == ST_IDLE) && refPending;
    refFire   = refTimer == RW'(T_REFI - 1);
    rasN      = !rasLowNow;
    strobe.latchReq = accept;
    strobe.casOn    = state == ST_CAS;
    strobe.refCas   = state inside {ST_RCSR, ST_RCHR};
    strobe.capture  = (state == ST_CAS) && (cnt == '0);
  end

  always_comb begin
    stateNext = state;
    cntNext   = (cnt != '0) ? cnt - CW'(1) : cnt;
    unique case (state)
      ST_IDLE:
        if (takeRef) begin
          stateNext = ST_RCSR; cntNext = CW'(T_CSR - 1);
        end else if (accept) begin
          stateNext = ST_RCD; cntNext = CW'(T_RCD - 1);
        end
      ST_RCD:
        if (cnt == '0) begin stateNext = ST_CAS; cntNext = CW'(T_CAS - 1); end
      ST_OPEN:
        if (accept) begin
          stateNext = ST_CAS; cntNext = CW'(T_CAS - 1);
        end else if (minMet && (refPending || nearMax || reqValid)) begin
          stateNext = ST_PRE; cntNext = CW'(T_RP - 1);
        end
      ST_CAS:
        if (cnt == '0) begin stateNext = ST_CP; cntNext = CW'(T_CP - 1); end
      ST_CP:
        if (cnt == '0) stateNext = ST_OPEN;
      ST_PRE:
        if (cnt == '0) stateNext = ST_IDLE;
      ST_RCSR:
        if (cnt == '0) begin stateNext = ST_RCHR; cntNext = CW'(T_CHR - 1); end
      ST_RCHR:
        if (cnt == '0) begin stateNext = ST_RHOLD; cntNext = CW'(T_RASMIN - T_CHR - 1); end
      ST_RHOLD:
        if (cnt == '0) begin stateNext = ST_PRE; cntNext = CW'(T_RP - 1); end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state          <= ST_IDLE;
      cnt            <= '0;
      rasLowCnt      <= '0;
      refTimer       <= '0;
      refPending     <= 1'b0;
      refreshOverdue <= 1'b0;
    end else begin
      state     <= stateNext;
      cnt       <= cntNext;
      rasLowCnt <= !rasLowNow ? '0 :
                   (rasLowCnt == AW'(T_RASMAX)) ? rasLowCnt : rasLowCnt + AW'(1);
      refTimer  <= refFire ? '0 : refTimer + RW'(1);
      if (refFire) refPending <= 1'b1;
      else if (takeRef) refPending <= 1'b0;
      if (refFire && refPending && !takeRef) refreshOverdue <= 1'b1;
    end
  end

  AST_RAS_MAX: assert property (@(posedge clk) disable iff (!rstN)
    rasLowNow |-> rasLowCnt < AW'(T_RASMAX)); // R9
  AST_OVERDUE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    refreshOverdue |=> refreshOverdue); // R10
  AST_REF_BLOCKS_HOST: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && refPending) |=> state == ST_RCSR); // R8
endmodule

// File: rtl/edo_datapath.sv
`timescale 1ns/1ps
module edo_datapath
  import edo_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int COL_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  edoStrobe_t        strobe,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LANES-1:0]  reqBe,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rowHit,
  output logic [COL_W-1:0]  dramAddr,
  output logic [LANES-1:0]  casN,
  output logic              weN,
  output logic              oeN,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe,
  input  logic [DATA_W-1:0] dqIn,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);
  localparam int ROW_W = ADDR_W - COL_W;

  logic [ROW_W-1:0]  rowQ;
  logic [COL_W-1:0]  colQ;
  logic [LANES-1:0]  beQ;
  logic              wrQ;
  logic [DATA_W-1:0] wdQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowQ <= '0; colQ <= '0; beQ <= '0; wrQ <= 1'b0; wdQ <= '0;
      rdValid <= 1'b0; rdData <= '0;
    end else begin
      if (strobe.latchReq) begin
        rowQ <= reqAddr[ADDR_W-1:COL_W];
        colQ <= reqAddr[COL_W-1:0];
        beQ  <= reqBe;
        wrQ  <= reqWrite;
        wdQ  <= reqWdata;
      end
      rdValid <= strobe.capture && !wrQ;
      if (strobe.capture && !wrQ) rdData <= dqIn;
    end
  end

  assign rowHit   = reqAddr[ADDR_W-1:COL_W] == rowQ;
  assign dramAddr = strobe.casOn ? colQ : COL_W'(rowQ);
  assign weN      = !(strobe.casOn && wrQ);
  assign oeN      = !(strobe.casOn && !wrQ);
  assign dqOe     = strobe.casOn && wrQ;
  assign dqOut    = wdQ;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign casN[i] = !((strobe.casOn && beQ[i]) || strobe.refCas);
  end

  AST_RDVALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid); // R4
  AST_WRITE_DRIVES_DQ: assert property (@(posedge clk) disable iff (!rstN)
    !weN |-> (dqOe && oeN)); // R3
endmodule

// File: rtl/edo_page_ctrl.sv
`timescale 1ns/1ps
module edo_page_ctrl
  import edo_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int COL_W    = 10,
  parameter int T_RCD    = 6,
  parameter int T_CAS    = 3,
  parameter int T_CP     = 2,
  parameter int T_RP     = 9,
  parameter int T_RASMIN = 12,
  parameter int T_RASMAX = 20000,
  parameter int T_REFI   = 3120,
  parameter int T_CSR    = 2,
  parameter int T_CHR    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LANES-1:0]  reqBe,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              refreshOverdue,
  output logic              dramRasN,
  output logic              dramCasLN,
  output logic              dramCasHN,
  output logic              dramWeN,
  output logic              dramOeN,
  output logic [COL_W-1:0]  dramAddr,
  output logic [DATA_W-1:0] dramDqOut,
  output logic              dramDqOe,
  input  logic [DATA_W-1:0] dramDqIn
);
  edoStrobe_t       strobe;
  logic             rowHit;
  logic [LANES-1:0] casN;

  edo_ctrl #(
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_RP(T_RP), .T_RASMIN(T_RASMIN),
    .T_RASMAX(T_RASMAX), .T_REFI(T_REFI), .T_CSR(T_CSR), .T_CHR(T_CHR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .rowHit(rowHit), .reqReady(reqReady),
    .rasN(dramRasN), .strobe(strobe), .refreshOverdue(refreshOverdue)
  );

  edo_datapath #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqBe(reqBe), .reqWdata(reqWdata), .rowHit(rowHit), .dramAddr(dramAddr),
    .casN(casN), .weN(dramWeN), .oeN(dramOeN), .dqOut(dramDqOut), .dqOe(dramDqOe),
    .dqIn(dramDqIn), .rdValid(rdValid), .rdData(rdData)
  );

  assign dramCasLN = casN[0];
  assign dramCasHN = casN[1];

  // Pin-level timing monitors for the assertions below.
  localparam int HW = $clog2(T_RP + T_RCD + 2);
  logic [HW-1:0] highRun, lowRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      highRun <= HW'(T_RP);
      lowRun  <= '0;
    end else if (dramRasN) begin
      lowRun  <= '0;
      highRun <= (highRun >= HW'(T_RP)) ? highRun : highRun + HW'(1);
    end else begin
      highRun <= '0;
      lowRun  <= (lowRun >= HW'(T_RCD)) ? lowRun : lowRun + HW'(1);
    end
  end

  AST_PRECHARGE_MIN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dramRasN) |-> highRun >= HW'(T_RP)); // R6
  AST_RAS_TO_CAS: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(dramCasLN && dramCasHN) && !dramRasN) |-> lowRun >= HW'(T_RCD)); // R2
  AST_CBR_FORM: assert property (@(posedge clk) disable iff (!rstN)
    (dramRasN && !(dramCasLN && dramCasHN)) |-> (!dramCasLN && !dramCasHN && dramWeN)); // R7
endmodule

// File: tb/edo_page_ctrl_bench.sv
`timescale 1ns/1ps
module edo_page_ctrl_bench;
  localparam int T_RCD = 3, T_CAS = 2, T_CP = 2, T_RP = 6, T_RASMIN = 10;
  localparam int T_RASMAX = 80, T_REFI = 300, T_CSR = 2, T_CHR = 2;

  typedef struct packed {
    logic        wr;
    logic [19:0] addr;
    logic [1:0]  be;
    logic [15:0] wd;
    logic [15:0] exp;
  } vec_t;

  // row = addr[19:10], column = addr[9:0]; be[0] low byte, be[1] high byte
  localparam vec_t VECS [8] = '{
    '{1'b1, 20'h00402, 2'b11, 16'hA5A5, 16'h0000},
    '{1'b1, 20'h00403, 2'b01, 16'h1234, 16'h0000},
    '{1'b0, 20'h00402, 2'b11, 16'h0000, 16'hA5A5},
    '{1'b1, 20'h00802, 2'b10, 16'hBEEF, 16'h0000},
    '{1'b0, 20'h00802, 2'b11, 16'h0000, 16'hBE00},
    '{1'b0, 20'h00403, 2'b11, 16'h0000, 16'h0034},
    '{1'b0, 20'h00403, 2'b10, 16'h0000, 16'h0000},
    '{1'b0, 20'h00403, 2'b01, 16'h0000, 16'h0034}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [19:0] reqAddr = '0;
  logic [1:0]  reqBe = '0;
  logic [15:0] reqWdata = '0;
  logic reqReady, rdValid, refreshOverdue;
  logic [15:0] rdData;
  logic dramRasN, dramCasLN, dramCasHN, dramWeN, dramOeN, dramDqOe;
  logic [9:0]  dramAddr;
  logic [15:0] dramDqOut, dramDqIn;

  always #2.5 clk = ~clk;

  edo_page_ctrl #(
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_RP(T_RP), .T_RASMIN(T_RASMIN),
    .T_RASMAX(T_RASMAX), .T_REFI(T_REFI), .T_CSR(T_CSR), .T_CHR(T_CHR)
  ) u_edo_page_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqBe(reqBe), .reqWdata(reqWdata), .rdValid(rdValid), .rdData(rdData),
    .refreshOverdue(refreshOverdue), .dramRasN(dramRasN), .dramCasLN(dramCasLN),
    .dramCasHN(dramCasHN), .dramWeN(dramWeN), .dramOeN(dramOeN), .dramAddr(dramAddr),
    .dramDqOut(dramDqOut), .dramDqOe(dramDqOe), .dramDqIn(dramDqIn)
  );

  // Second instance: interval shorter than one refresh cycle
  logic o2Ready, o2RdValid, o2Overdue, o2Ras, o2CasL, o2CasH, o2We, o2Oe, o2DqOe;
  logic [15:0] o2RdData, o2DqOut;
  logic [9:0]  o2Addr;
  edo_page_ctrl #(
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_RP(T_RP), .T_RASMIN(T_RASMIN),
    .T_RASMAX(T_RASMAX), .T_REFI(12), .T_CSR(T_CSR), .T_CHR(T_CHR)
  ) u_edo_page_ctrl_ovd (
    .clk(clk), .rstN(rstN), .reqValid(1'b0), .reqReady(o2Ready), .reqWrite(1'b0),
    .reqAddr(20'h0), .reqBe(2'b00), .reqWdata(16'h0), .rdValid(o2RdValid), .rdData(o2RdData),
    .refreshOverdue(o2Overdue), .dramRasN(o2Ras), .dramCasLN(o2CasL), .dramCasHN(o2CasH),
    .dramWeN(o2We), .dramOeN(o2Oe), .dramAddr(o2Addr), .dramDqOut(o2DqOut),
    .dramDqOe(o2DqOe), .dramDqIn(16'h0)
  );

  // DRAM model and pin-timing monitor
  logic [15:0] mem [256];
  logic [9:0]  curRow = '0;
  int rasLowRun = 0, rasHighRun = 1000, csrRun = 0, chrRun = 0, inRef = 0;
  int opens = 0, refreshes = 0, rcdBad = 0, rpBad = 0, cbrBad = 0, rasMaxSeen = 0;
  logic prevRas = 1'b1, prevCasLow = 1'b0;

  initial for (int i = 0; i < 256; i++) mem[i] = '0;

  always_comb begin
    dramDqIn = '0;
    if (!dramRasN && !dramOeN) begin
      if (!dramCasLN) dramDqIn[7:0]  = mem[{curRow[3:0], dramAddr[3:0]}][7:0];
      if (!dramCasHN) dramDqIn[15:8] = mem[{curRow[3:0], dramAddr[3:0]}][15:8];
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      automatic logic casLow = !dramCasLN || !dramCasHN;
      if (dramRasN && casLow && !prevCasLow && rasHighRun < T_RP) cbrBad++;   // R8
      if (prevRas && !dramRasN) begin
        if (rasHighRun < T_RP) rpBad++;
        if (casLow) begin
          refreshes++; inRef = 1; chrRun = 0;
          if (csrRun < T_CSR || !dramWeN || dramCasLN || dramCasHN) cbrBad++;
        end else begin
          opens++; curRow = dramAddr;
        end
      end
      if (inRef == 1 && !dramRasN && casLow) chrRun++;
      if (inRef == 1 && !casLow) begin
        if (chrRun < T_CHR) cbrBad++;
        inRef = 0;
      end
      if (!prevCasLow && casLow && !dramRasN) begin
        if (rasLowRun < T_RCD) rcdBad++;
        if (!dramWeN) begin
          if (!dramCasLN) mem[{curRow[3:0], dramAddr[3:0]}][7:0]  = dramDqOut[7:0];
          if (!dramCasHN) mem[{curRow[3:0], dramAddr[3:0]}][15:8] = dramDqOut[15:8];
        end
      end
      csrRun = (dramRasN && casLow) ? csrRun + 1 : 0;
      if (dramRasN) begin rasHighRun++; rasLowRun = 0; end
      else begin rasLowRun++; rasHighRun = 0; end
      if (rasLowRun > rasMaxSeen) rasMaxSeen = rasLowRun;
      prevRas = dramRasN;
      prevCasLow = casLow;
    end
  end

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReq(input logic wr, input logic [19:0] a, input logic [1:0] be,
                       input logic [15:0] wd, output logic [15:0] rd, output bit ok);
    int n;
    ok = 1'b0; rd = '0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqBe = be; reqWdata = wd;
    #1;
    n = 0;
    while (!reqReady && n < 1000) begin @(negedge clk); n++; end
    if (!reqReady) begin reqValid = 1'b0; return; end
    @(negedge clk);
    reqValid = 1'b0;
    if (wr) begin ok = 1'b1; return; end
    n = 0;
    while (!rdValid && n < 100) begin @(negedge clk); n++; end
    if (rdValid) begin rd = rdData; ok = 1'b1; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    bit ok;
    int o0, r0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(dramRasN && dramCasLN && dramCasHN, "R1 strobes", {dramRasN, dramCasLN, dramCasHN}, 7);
    chk(dramWeN && dramOeN, "R1 we/oe", {dramWeN, dramOeN}, 3);
    chk(!rdValid && !refreshOverdue && reqReady, "R1 flags",
        {rdValid, refreshOverdue, reqReady}, 1);
    rstN = 1'b1;

    // Vector table: R2 R3 R4
    foreach (VECS[i]) begin
      doReq(VECS[i].wr, VECS[i].addr, VECS[i].be, VECS[i].wd, rd, ok);
      if (VECS[i].wr) chk(ok, "R3 write accepted", ok, 1);
      else chk(ok && rd == VECS[i].exp, "R3/R4 readback", rd, VECS[i].exp);
    end

    // R5: page hit reuses the open row
    doReq(1'b0, 20'h00402, 2'b11, 16'h0, rd, ok);
    o0 = opens; r0 = refreshes;
    doReq(1'b0, 20'h00403, 2'b11, 16'h0, rd, ok);
    chk(ok && rd == 16'h0034, "R5 hit data", rd, 16'h0034);
    chk((opens - o0) <= (refreshes - r0), "R5 no reopen", opens - o0, refreshes - r0);

    // R6: row miss reopens with row address on the bus
    o0 = opens;
    doReq(1'b0, 20'h00802, 2'b11, 16'h0, rd, ok);
    chk(ok && rd == 16'hBE00, "R6 miss data", rd, 16'hBE00);
    chk(opens > o0 && curRow == 10'd2, "R6/R2 new row opened", curRow, 2);

    // R7 / R9: idle window
    r0 = refreshes;
    repeat (1200) @(negedge clk);
    chk((refreshes - r0) >= 3 && (refreshes - r0) <= 5, "R7 refresh count", refreshes - r0, 4);
    chk(cbrBad == 0, "R7/R8 refresh ordering", cbrBad, 0);
    chk(rasMaxSeen <= T_RASMAX && rasMaxSeen >= T_RASMAX - 10, "R9 ras low max",
        rasMaxSeen, T_RASMAX);
    chk(rcdBad == 0, "R2 ras-to-cas", rcdBad, 0);
    chk(rpBad == 0, "R6 precharge", rpBad, 0);
    chk(!refreshOverdue, "R10 no overdue", refreshOverdue, 0);
    chk(o2Overdue, "R10 overdue set", o2Overdue, 1);
    repeat (50) @(negedge clk);
    chk(o2Overdue, "R10 overdue sticky", o2Overdue, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule